// File: doc/BRIEF.md
# Matrix Keypad Scanner with Debounce

This block scans a key matrix of four rows by three columns. It pulls one row low at a time and watches the active-low column lines for a zero. When a column reads low, the scanner stops on that row and waits until the column pattern has been steady for a programmable number of clock cycles. It then reports the key once, as a one-cycle make pulse with a key number.

While the key stays down, the row drive remains on the detected row, so the block can watch for the release. A release that stays steady for the same debounce interval produces a one-cycle break pulse, and scanning then resumes.

The key number is worked out arithmetically from the 1-based row and column: the column number, plus three times the row number, minus three. Keys are therefore numbered 1 to 12, row by row. Column lines pass through a two-flop synchroniser before any logic uses them.

Top module: `keypad_scanner`

## Requirements
- R1: During and right after reset, `rowsOut` is 4'b1110 (bit i drives row i+1, so row 1 is low), `keyCode` is 0, and both pulses are low.
- R2: While no key is pressed, exactly one row is low at any time. The low row steps 1, 2, 3, 4 and back to 1, and each row stays low for exactly three clock cycles.
- R3: The reported key number is col + 3*row - 3, with row and column counted from 1. Bit j of `colsIn` is column j+1. When more than one column reads low, the lowest-numbered one is used.
- R4: A make is reported only after the column pattern on the parked row has stayed unchanged and not all-high for DEBOUNCE_CYCLES consecutive cycles. A change in the pattern restarts the count. A closure shorter than that interval produces no make.
- R5: `makePulse` is high for exactly one cycle. `keyCode` carries the key number in that same cycle and keeps it until the next make.
- R6: A key held down for any length of time gives a single make. While it is held, `rowsOut` stays on the detected row.
- R7: `breakPulse` is a one-cycle pulse. It is raised after all columns have read high for DEBOUNCE_CYCLES consecutive cycles following a make. A shorter release produces neither a break nor a new make, and `keyCode` is unchanged at the break.
- R8: After a break, scanning resumes, and a later press of any key produces a new make.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| colsIn | input | 3 | Column lines from the matrix, active low, asynchronous |
| rowsOut | output | 4 | Row drives, active low, one row low at a time |
| keyCode | output | 4 | Key number 1..12 of the last make |
| makePulse | output | 1 | One-cycle pulse when a closure is confirmed |
| breakPulse | output | 1 | One-cycle pulse when a release is confirmed |

## Verification
The hardest situation to reach from the ports is a release that comes back partway through the break debounce. The key has to be released and re-pressed while the scanner is parked, after the make has been reported and before the release count expires. The bench gets there by waiting for the make pulse, dropping the key for half the debounce interval, and pressing it again. It then confirms that neither a break nor a second make appears and that the row stays parked. A further case aborts the make debounce by pressing a key for too short a time. In that case the scanner must return to rotating the rows without reporting anything.

// File: rtl/kpd_pkg.sv
package kpd_pkg;

  typedef struct packed {
    logic scanEn;       // row dwell counter runs
    logic rowAdvance;   // step to next row
    logic captureCols;  // store current column pattern
    logic dbClear;      // restart debounce count
    logic loadCode;     // confirm make, load key number
    logic breakEvt;     // confirm break
  } kpdStrobes_t;

  typedef enum logic [1:0] {
    ST_SCAN       = 2'd0,
    ST_MAKE_WAIT  = 2'd1,
    ST_HELD       = 2'd2,
    ST_BREAK_WAIT = 2'd3
  } kpdState_t;

endpackage

// File: rtl/kpd_datapath.sv
module kpd_datapath
  import kpd_pkg::*;
#(
  parameter int ROWS            = 4,
  parameter int COLS            = 3,
  parameter int DEBOUNCE_CYCLES = 16,
  parameter int SYNC_STAGES     = 2
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic [COLS-1:0]                 colsIn,
  input  kpdStrobes_t                     strobes,
  output logic                            dwellDone,
  output logic                            anyLow,
  output logic                            sameAsCaptured,
  output logic                            dbDone,
  output logic [ROWS-1:0]                 rowsOut,
  output logic [$clog2(ROWS*COLS+1)-1:0]  keyCode,
  output logic                            makePulse,
  output logic                            breakPulse
);

  localparam int ROW_W   = $clog2(ROWS);
  localparam int COL_W   = (COLS > 1) ? $clog2(COLS) : 1;
  localparam int CODE_W  = $clog2(ROWS*COLS+1);
  localparam int DB_W    = $clog2(DEBOUNCE_CYCLES);
  localparam int SETTLE  = SYNC_STAGES + 1;
  localparam int DWELL_W = $clog2(SETTLE + 1);

  // column synchroniser chain
  logic [COLS-1:0] syncChain [SYNC_STAGES];
  logic [COLS-1:0] colSync;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < SYNC_STAGES; s++) syncChain[s] <= '1;
    end else begin
      syncChain[0] <= colsIn;
      for (int s = 1; s < SYNC_STAGES; s++) syncChain[s] <= syncChain[s-1];
    end
  end
  assign colSync = syncChain[SYNC_STAGES-1];

  // row selection
  logic [ROW_W-1:0] rowIdx;
  always_ff @(posedge clk) begin
    if (rst) rowIdx <= '0;
    else if (strobes.rowAdvance)
      rowIdx <= (rowIdx == ROW_W'(ROWS-1)) ? '0 : rowIdx + 1'b1;
  end

  genvar r;
  generate
    for (r = 0; r < ROWS; r++) begin : g_row
      assign rowsOut[r] = (rowIdx != ROW_W'(r));
    end
  endgenerate

  // dwell on each row long enough for the synchroniser to settle
  logic [DWELL_W-1:0] dwellCnt;
  always_ff @(posedge clk) begin
    if (rst || !strobes.scanEn || strobes.rowAdvance) dwellCnt <= '0;
    else dwellCnt <= dwellCnt + 1'b1;
  end
  assign dwellDone = strobes.scanEn && (dwellCnt == DWELL_W'(SETTLE-1));

  // captured column pattern
  logic [COLS-1:0] capturedCols;
  always_ff @(posedge clk) begin
    if (rst) capturedCols <= '1;
    else if (strobes.captureCols) capturedCols <= colSync;
  end
  assign anyLow         = (colSync != '1);
  assign sameAsCaptured = (colSync == capturedCols);

  // debounce counter
  logic [DB_W-1:0] dbCount;
  always_ff @(posedge clk) begin
    if (rst || strobes.dbClear) dbCount <= '0;
    else if (!dbDone) dbCount <= dbCount + 1'b1;
  end
  assign dbDone = (dbCount == DB_W'(DEBOUNCE_CYCLES-1));

  // key number: zero-based col + COLS*row + 1
  logic [COL_W-1:0]  lowCol;
  logic [CODE_W-1:0] codeNext;
  always_comb begin
    lowCol = '0;
    for (int j = COLS-1; j >= 0; j--)
      if (!capturedCols[j]) lowCol = COL_W'(j);
  end
  assign codeNext = CODE_W'(lowCol) + CODE_W'(COLS) * CODE_W'(rowIdx) + CODE_W'(1);

  always_ff @(posedge clk) begin
    if (rst) begin
      keyCode    <= '0;
      makePulse  <= 1'b0;
      breakPulse <= 1'b0;
    end else begin
      if (strobes.loadCode) keyCode <= codeNext;
      makePulse  <= strobes.loadCode;
      breakPulse <= strobes.breakEvt;
    end
  end

  // assertion support: key currently reported as down
  logic heldFlag;
  always_ff @(posedge clk) begin
    if (rst) heldFlag <= 1'b0;
    else if (makePulse) heldFlag <= 1'b1;
    else if (breakPulse) heldFlag <= 1'b0;
  end

  assert_row_step_R2: assert property (@(posedge clk) disable iff (rst)
    (rowIdx != $past(rowIdx)) |->
      (rowIdx == (($past(rowIdx) == ROW_W'(ROWS-1)) ? '0 : $past(rowIdx) + 1'b1)));

  assert_one_row_low_R2: assert property (@(posedge clk) disable iff (rst)
    $countones(~rowsOut) == 1);

  assert_code_range_R3: assert property (@(posedge clk) disable iff (rst)
    makePulse |-> (keyCode >= CODE_W'(1) && keyCode <= CODE_W'(ROWS*COLS)));

  assert_make_single_R5: assert property (@(posedge clk) disable iff (rst)
    makePulse |=> !makePulse);

  assert_one_make_per_hold_R6: assert property (@(posedge clk) disable iff (rst)
    makePulse |-> !heldFlag);

  assert_break_after_make_R7: assert property (@(posedge clk) disable iff (rst)
    breakPulse |-> (heldFlag && !makePulse));

  assert_code_kept_R7: assert property (@(posedge clk) disable iff (rst)
    breakPulse |-> $stable(keyCode));

endmodule

// File: rtl/kpd_control.sv
module kpd_control
  import kpd_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        dwellDone,
  input  logic        anyLow,
  input  logic        sameAsCaptured,
  input  logic        dbDone,
  output kpdStrobes_t strobes
);

  kpdState_t state, stateNext;

  always_ff @(posedge clk) begin
    if (rst) state <= ST_SCAN;
    else state <= stateNext;
  end

  always_comb begin
    stateNext = state;
    strobes   = '0;
    unique case (state)
      ST_SCAN: begin
        strobes.scanEn = 1'b1;
        if (dwellDone) begin
          if (anyLow) begin
            strobes.captureCols = 1'b1;
            strobes.dbClear     = 1'b1;
            stateNext           = ST_MAKE_WAIT;
          end else begin
            strobes.rowAdvance = 1'b1;
          end
        end
      end
      ST_MAKE_WAIT: begin
        if (!anyLow) begin
          strobes.rowAdvance = 1'b1;
          stateNext          = ST_SCAN;
        end else if (!sameAsCaptured) begin
          strobes.captureCols = 1'b1;
          strobes.dbClear     = 1'b1;
        end else if (dbDone) begin
          strobes.loadCode = 1'b1;
          stateNext        = ST_HELD;
        end
      end
      ST_HELD: begin
        if (!anyLow) begin
          strobes.dbClear = 1'b1;
          stateNext       = ST_BREAK_WAIT;
        end
      end
      ST_BREAK_WAIT: begin
        if (anyLow) begin
          stateNext = ST_HELD;
        end else if (dbDone) begin
          strobes.breakEvt   = 1'b1;
          strobes.rowAdvance = 1'b1;
          stateNext          = ST_SCAN;
        end
      end
      default: stateNext = ST_SCAN;
    endcase
  end

  assert_parked_when_held_R6: assert property (@(posedge clk) disable iff (rst)
    (state == ST_HELD) |-> !strobes.rowAdvance);

  assert_make_needs_debounce_R4: assert property (@(posedge clk) disable iff (rst)
    strobes.loadCode |-> (state == ST_MAKE_WAIT && $past(anyLow) && $past(state) == ST_MAKE_WAIT));

endmodule

// File: rtl/keypad_scanner.sv
module keypad_scanner
  import kpd_pkg::*;
#(
  parameter int ROWS            = 4,
  parameter int COLS            = 3,
  parameter int DEBOUNCE_CYCLES = 16
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic [COLS-1:0]                colsIn,
  output logic [ROWS-1:0]                rowsOut,
  output logic [$clog2(ROWS*COLS+1)-1:0] keyCode,
  output logic                           makePulse,
  output logic                           breakPulse
);

  kpdStrobes_t strobes;
  logic dwellDone, anyLow, sameAsCaptured, dbDone;

  kpd_control u_control (
    .clk            (clk),
    .rst            (rst),
    .dwellDone      (dwellDone),
    .anyLow         (anyLow),
    .sameAsCaptured (sameAsCaptured),
    .dbDone         (dbDone),
    .strobes        (strobes)
  );

  kpd_datapath #(
    .ROWS            (ROWS),
    .COLS            (COLS),
    .DEBOUNCE_CYCLES (DEBOUNCE_CYCLES),
    .SYNC_STAGES     (2)
  ) u_datapath (
    .clk            (clk),
    .rst            (rst),
    .colsIn         (colsIn),
    .strobes        (strobes),
    .dwellDone      (dwellDone),
    .anyLow         (anyLow),
    .sameAsCaptured (sameAsCaptured),
    .dbDone         (dbDone),
    .rowsOut        (rowsOut),
    .keyCode        (keyCode),
    .makePulse      (makePulse),
    .breakPulse     (breakPulse)
  );

endmodule

// File: tb/keypad_scanner_bench.sv
`timescale 1ns/1ps
module keypad_scanner_bench;

  localparam int ROWS = 4;
  localparam int COLS = 3;
  localparam int DB   = 16;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [2:0] colsIn;
  logic [3:0] rowsOut;
  logic [3:0] keyCode;
  logic       makePulse, breakPulse;

  int checks = 0;
  int errors = 0;
  int makeCount = 0;
  int breakCount = 0;
  bit finished = 1'b0;

  // key matrix model
  logic pressed = 1'b0;
  int   pressRow = 0;  // 0-based
  int   pressCol = 0;  // 0-based

  always_comb begin
    colsIn = 3'b111;
    if (pressed && rowsOut[pressRow] == 1'b0) colsIn[pressCol] = 1'b0;
  end

  always #5 clk = ~clk;

  keypad_scanner #(.ROWS(ROWS), .COLS(COLS), .DEBOUNCE_CYCLES(DB)) u_keypad_scanner (
    .clk(clk), .rst(rst), .colsIn(colsIn), .rowsOut(rowsOut),
    .keyCode(keyCode), .makePulse(makePulse), .breakPulse(breakPulse)
  );

  always @(negedge clk) begin
    if (!rst && makePulse) makeCount++;
    if (!rst && breakPulse) breakCount++;
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int expCode(input int row1, input int col1);
    return col1 + 3*row1 - 3;
  endfunction

  // waits for a make; returns cycles waited or -1
  task automatic wait_make(input int limit, output int cyc);
    cyc = -1;
    for (int i = 1; i <= limit; i++) begin
      tick(1);
      if (makePulse) begin cyc = i; break; end
    end
  endtask

  task automatic wait_break(input int limit, output int cyc);
    cyc = -1;
    for (int i = 1; i <= limit; i++) begin
      tick(1);
      if (breakPulse) begin cyc = i; break; end
    end
  endtask

  task automatic test_reset();
    rst = 1'b1;
    tick(4);
    check(rowsOut == 4'b1110, "R1 rows in reset", rowsOut, 4'b1110);
    rst = 1'b0;
    tick(1);
    check(rowsOut == 4'b1110, "R1 rows after reset", rowsOut, 4'b1110);
    check(keyCode == 0, "R1 keyCode after reset", keyCode, 0);
    check(!makePulse && !breakPulse, "R1 pulses after reset", {makePulse, breakPulse}, 0);
  endtask

  task automatic test_scan();
    int lowIdx, prevIdx, runLen, badOne, badStep, badDwell, changes;
    badOne = 0; badStep = 0; badDwell = 0; changes = 0;
    prevIdx = -1; runLen = 0;
    for (int i = 0; i < 60; i++) begin
      tick(1);
      if ($countones(~rowsOut) != 1) badOne++;
      lowIdx = 0;
      for (int r = 0; r < ROWS; r++) if (!rowsOut[r]) lowIdx = r;
      if (prevIdx >= 0 && lowIdx != prevIdx) begin
        if (lowIdx != (prevIdx + 1) % ROWS) badStep++;
        if (changes > 0 && runLen != 3) badDwell++;
        changes++;
        runLen = 1;
      end else runLen++;
      prevIdx = lowIdx;
    end
    check(badOne == 0, "R2 exactly one row low", badOne, 0);
    check(badStep == 0, "R2 row order", badStep, 0);
    check(badDwell == 0, "R2 three cycles per row", badDwell, 0);
    check(changes >= 15, "R2 rows keep rotating", changes, 15);
  endtask

  task automatic press_release(input int row0, input int col0);
    int cyc, m0, b0, code;
    m0 = makeCount; b0 = breakCount;
    code = expCode(row0 + 1, col0 + 1);
    pressRow = row0; pressCol = col0; pressed = 1'b1;
    wait_make(200, cyc);
    check(cyc > DB, "R4 make latency not below debounce", cyc, DB + 1);
    check(keyCode == code, "R3 key number at make", keyCode, code);
    tick(1);
    check(!makePulse, "R5 make lasts one cycle", makePulse, 0);
    check(keyCode == code, "R5 key number held", keyCode, code);
    pressed = 1'b0;
    wait_break(200, cyc);
    check(cyc >= DB, "R7 break after full release interval", cyc, DB);
    check(keyCode == code, "R7 key number at break", keyCode, code);
    tick(1);
    check(!breakPulse, "R7 break lasts one cycle", breakPulse, 0);
    check(makeCount == m0 + 1 && breakCount == b0 + 1, "R8 one make and one break",
          (makeCount - m0) * 10 + (breakCount - b0), 11);
    tick(10);
  endtask

  task automatic test_all_keys();
    for (int r = 0; r < ROWS; r++)
      for (int c = 0; c < COLS; c++) press_release(r, c);
  endtask

  task automatic test_bounce();
    int m0;
    m0 = makeCount;
    pressRow = 2; pressCol = 1;
    for (int k = 0; k < 8; k++) begin
      pressed = 1'b1; tick(DB / 2);
      pressed = 1'b0; tick(3);
    end
    tick(4 * DB);
    check(makeCount == m0, "R4 short closures give no make", makeCount - m0, 0);
    check($countones(~rowsOut) == 1, "R2 scanning after aborted debounce", $countones(~rowsOut), 1);
  endtask

  task automatic test_multi_column();
    int cyc;
    // two columns on row 2 at once: model forces cols 2 and 3 low
    pressRow = 1; pressCol = 2; pressed = 1'b1;
    force colsIn = (rowsOut[1] == 1'b0) ? 3'b001 : 3'b111;
    wait_make(200, cyc);
    check(keyCode == expCode(2, 2), "R3 lowest low column wins", keyCode, expCode(2, 2));
    release colsIn;
    pressed = 1'b0;
    wait_break(200, cyc);
    tick(10);
  endtask

  task automatic test_hold_and_glitch();
    int cyc, m0, b0, moved;
    logic [3:0] parked;
    pressRow = 3; pressCol = 0; pressed = 1'b1;
    wait_make(200, cyc);
    check(keyCode == expCode(4, 1), "R3 key number row 4 col 1", keyCode, expCode(4, 1));
    m0 = makeCount; b0 = breakCount;
    parked = rowsOut;
    moved = 0;
    for (int i = 0; i < 10 * DB; i++) begin
      tick(1);
      if (rowsOut != parked) moved++;
    end
    check(parked == 4'b0111, "R6 parked on detected row", parked, 4'b0111);
    check(moved == 0, "R6 row stays parked while held", moved, 0);
    check(makeCount == m0, "R6 single make while held", makeCount - m0, 0);
    // release shorter than the debounce interval
    pressed = 1'b0; tick(DB / 2);
    pressed = 1'b1; tick(3 * DB);
    check(breakCount == b0, "R7 short release gives no break", breakCount - b0, 0);
    check(makeCount == m0, "R7 short release gives no new make", makeCount - m0, 0);
    check(rowsOut == 4'b0111, "R6 still parked after glitch", rowsOut, 4'b0111);
    pressed = 1'b0;
    wait_break(200, cyc);
    check(cyc > 0, "R7 break after real release", cyc, 1);
    tick(10);
    // scanning resumes and a new press is seen
    pressRow = 0; pressCol = 2; pressed = 1'b1;
    wait_make(200, cyc);
    check(cyc > 0 && keyCode == expCode(1, 3), "R8 new make after break", keyCode, expCode(1, 3));
    pressed = 1'b0;
    wait_break(200, cyc);
    tick(5);
  endtask

  initial begin
    #2_000_000;
    if (!finished) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    test_reset();
    test_scan();
    test_all_keys();
    test_bounce();
    test_multi_column();
    test_hold_and_glitch();
    finished = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule